// File: doc/BRIEF.md
# Transmit Frame Assembly FIFO

This block collects a frame for transmission one 32-bit word at a time and then plays it out as a byte stream. Software pushes words through a data port. The first word pushed into an empty buffer carries the payload length in its low half, and its upper half holds the first two frame bytes. The words land in a byte buffer with the least significant byte first. After each accepted word the block checks two things: whether enough bytes are held to cover the whole frame, and whether a programmable fill level has been passed. When both hold, it starts sending on its own.

Sending reads the buffer from byte 2 onward, which skips the length field. It emits the header plus payload (length + 14 bytes) on a valid/ready byte interface and marks the final byte with last. If padding is enabled, short frames are filled out with zero bytes. A transmit-request strobe forces a send of whatever the buffer holds. An over-long length word is refused and raises an error flag. Acknowledging that flag also empties the buffer. A completed send empties the buffer and raises an empty flag. No words are taken while a send is in progress.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset, wrReady is 1, outValid is 0, txErr is 0 and txEmpty is 0.
- R2: Each accepted word is stored as four bytes in ascending address order, with wrData[7:0] at the lowest address. Output byte k of a frame is buffer byte k+2, and the length is buffer bytes 0 (low) and 1 (high).
- R3: A word that would take the stored count beyond BUF_BYTES is discarded, and the bytes already stored are unchanged.
- R4: When the buffer is empty, a word whose bits 15:0 exceed BUF_BYTES-16 is not stored and sets txErr, so the buffer stays empty.
- R5: A frame is complete once the stored count reaches length+16 when autoCrc is 1, or length+20 when autoCrc is 0. This amount is limited to BUF_BYTES.
- R6: The fill level is passed only when thrCfg is not all ones and the stored count is at least 32*thrCfg+4. All ones disables automatic start.
- R7: On the cycle after an accepted word for which both R5 and R6 hold, outValid rises. Otherwise it stays low.
- R8: A sent frame is length+14 bytes long, limited to BUF_BYTES-2. When padEn was 1 at the start and length+14 < 60, zero bytes follow it up to 60 bytes.
- R9: A kick pulse while idle starts a send of the current contents on the next cycle, whether or not the frame is complete.
- R10: After the last byte is taken, the buffer is empty and txEmpty is 1 until an emptyAck pulse clears it.
- R11: An errAck pulse clears txErr and empties the buffer, so the next accepted word is treated as a length word.
- R12: wrReady is 0 for as long as a send is in progress.
- R13: outData and outLast hold steady while outValid is 1 and outReady is 0. outLast is 1 only on the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Data word write request |
| wrData | input | 32 | Data word |
| wrReady | output | 1 | Word accepted when high together with wrValid |
| kick | input | 1 | Transmit-request strobe |
| errAck | input | 1 | Clears txErr and empties the buffer |
| emptyAck | input | 1 | Clears txEmpty |
| thrCfg | input | THR_W | Start fill level; all ones disables automatic start |
| padEn | input | 1 | Pad short frames to 60 bytes |
| autoCrc | input | 1 | 1: the buffer holds no trailing check bytes |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Output byte taken |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Final byte of the frame |
| txErr | output | 1 | Over-long length was refused |
| txEmpty | output | 1 | A send completed |

## Verification
The bench builds the block with BUF_BYTES = 256 and THR_W = 6. With this size a full buffer takes 64 words, so the overflow drop and the capped completion amount (a length of 240 with autoCrc off needs 260 bytes, limited to 256) are reached in a few hundred cycles. Refused lengths begin at 241. Fill levels 0 to 3 sit well inside the buffer, so the interplay between fill level and completeness shows up on ordinary frames.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic push;     // store wrData
    logic clear;    // empty the buffer this cycle
    logic start;    // latch frame geometry, begin streaming
    logic advance;  // current output byte taken
  } txfStrobes_t;

  // Datapath -> control status
  typedef struct packed {
    logic tooLong;  // incoming word would be an oversized length word
    logic autoGo;   // after this push, fill level and completeness both hold
    logic lastByte; // stream position is on the final byte
  } txfStatus_t;

endpackage

// File: rtl/txf_datapath.sv
module txf_datapath
  import tx_frame_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int THR_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  txfStrobes_t      stb,
  input  logic [31:0]      wrData,
  input  logic [THR_W-1:0] thrCfg,
  input  logic             padEn,
  input  logic             autoCrc,
  output txfStatus_t       stat,
  output logic [7:0]       outData
);

  localparam int WORDS   = BUF_BYTES / 4;
  localparam int WA_W    = $clog2(WORDS);
  localparam int POS_W   = WA_W + 2;
  localparam int CNT_W   = $clog2(BUF_BYTES + 1);
  localparam int LW      = 17;
  localparam int MAX_LEN = BUF_BYTES - 16;
  localparam int OUT_MAX = BUF_BYTES - 2;
  localparam int PAD_MIN = 60;
  localparam logic [THR_W-1:0] THR_OFF = '1;

  logic [31:0]      memWords [WORDS];
  logic [CNT_W-1:0] byteCount, effCount, nextCount;
  logic             fits;
  logic [LW-1:0]    hdrLen, needRaw, needLen, sendRaw, dataCap, thrLevel, cntExt;
  logic             thrHit;
  logic [POS_W-1:0] pos, dataLen, frameLen, rdAddr;
  logic [31:0]      rdWord;
  logic [7:0]       rdByte;

  // Fill side
  assign effCount  = stb.clear ? '0 : byteCount;
  assign fits      = (LW'(effCount) + LW'(4)) <= LW'(BUF_BYTES);
  assign nextCount = (stb.push && fits) ? effCount + CNT_W'(4) : effCount;

  assign hdrLen = (stb.push && effCount == '0) ? {1'b0, wrData[15:0]}
                                               : {1'b0, memWords[0][15:0]};
  assign stat.tooLong = (effCount == '0) && (LW'(wrData[15:0]) > LW'(MAX_LEN));

  // Completeness and fill level
  assign needRaw  = hdrLen + (autoCrc ? LW'(16) : LW'(20));
  assign needLen  = (needRaw > LW'(BUF_BYTES)) ? LW'(BUF_BYTES) : needRaw;
  assign cntExt   = LW'(nextCount);
  assign thrLevel = (LW'(thrCfg) << 5) + LW'(4);
  assign thrHit   = (thrCfg != THR_OFF) && (cntExt >= thrLevel);
  assign stat.autoGo = thrHit && (cntExt >= needLen);

  // Frame geometry
  assign sendRaw = hdrLen + LW'(14);
  assign dataCap = (sendRaw > LW'(OUT_MAX)) ? LW'(OUT_MAX) : sendRaw;

  always_ff @(posedge clk) begin
    if (stb.push && fits)
      memWords[effCount[WA_W+1:2]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount <= '0;
      pos       <= '0;
      dataLen   <= '0;
      frameLen  <= '0;
    end else begin
      if (stb.advance && stat.lastByte) byteCount <= '0;
      else                              byteCount <= nextCount;

      if (stb.start) begin
        pos      <= '0;
        dataLen  <= POS_W'(dataCap);
        frameLen <= (padEn && sendRaw < LW'(PAD_MIN)) ? POS_W'(PAD_MIN)
                                                      : POS_W'(dataCap);
      end else if (stb.advance) begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  // Drain side: byte k of the frame is buffer byte k+2
  assign rdAddr        = pos + POS_W'(2);
  assign rdWord        = memWords[rdAddr[POS_W-1:2]];
  assign rdByte        = rdWord[8*rdAddr[1:0] +: 8];
  assign outData       = (pos < dataLen) ? rdByte : 8'h00;
  assign stat.lastByte = (pos == frameLen - POS_W'(1));

endmodule

// File: rtl/txf_control.sv
module txf_control
  import tx_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        kick,
  input  logic        errAck,
  input  logic        emptyAck,
  input  logic        outReady,
  input  txfStatus_t  stat,
  output txfStrobes_t stb,
  output logic        wrReady,
  output logic        outValid,
  output logic        outLast,
  output logic        txErr,
  output logic        txEmpty
);

  logic sending, accept, finish;

  assign wrReady = !sending;
  assign accept  = wrValid && !sending;

  always_comb begin
    stb.clear   = errAck;
    stb.push    = accept && !stat.tooLong;
    stb.start   = !sending && (kick || (stb.push && stat.autoGo));
    stb.advance = sending && outReady;
  end

  assign finish   = stb.advance && stat.lastByte;
  assign outValid = sending;
  assign outLast  = sending && stat.lastByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sending <= 1'b0;
      txErr   <= 1'b0;
      txEmpty <= 1'b0;
    end else begin
      if (stb.start)   sending <= 1'b1;
      else if (finish) sending <= 1'b0;

      if (accept && stat.tooLong) txErr <= 1'b1;
      else if (errAck)            txErr <= 1'b0;

      if (finish)        txEmpty <= 1'b1;
      else if (emptyAck) txEmpty <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tx_frame_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int THR_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [31:0]      wrData,
  output logic             wrReady,
  input  logic             kick,
  input  logic             errAck,
  input  logic             emptyAck,
  input  logic [THR_W-1:0] thrCfg,
  input  logic             padEn,
  input  logic             autoCrc,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             txErr,
  output logic             txEmpty
);

  txfStrobes_t stb;
  txfStatus_t  stat;

  txf_control ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .kick(kick),
    .errAck(errAck), .emptyAck(emptyAck), .outReady(outReady),
    .stat(stat), .stb(stb), .wrReady(wrReady), .outValid(outValid),
    .outLast(outLast), .txErr(txErr), .txEmpty(txEmpty)
  );

  txf_datapath #(.BUF_BYTES(BUF_BYTES), .THR_W(THR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .thrCfg(thrCfg),
    .padEn(padEn), .autoCrc(autoCrc), .stat(stat), .outData(outData)
  );

endmodule

// File: rtl/tx_frame_fifo_chk.sv
module tx_frame_fifo_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic       wrReady,
  input logic       kick,
  input logic       errAck,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       txErr,
  input logic       txEmpty
);

  a_r12_busy_blocks_writes: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !wrReady);

  a_r13_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  a_r10_empty_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (txEmpty && !outValid));

  a_r9_kick_starts: assert property (@(posedge clk) disable iff (!rstN)
    (kick && !outValid) |=> outValid);

  a_r11_ack_clears_error: assert property (@(posedge clk) disable iff (!rstN)
    (errAck && !wrValid) |=> !txErr);

endmodule

bind tx_frame_fifo tx_frame_fifo_chk chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .kick(kick),
  .errAck(errAck), .outValid(outValid), .outReady(outReady), .outData(outData),
  .outLast(outLast), .txErr(txErr), .txEmpty(txEmpty)
);

// File: tb/tx_frame_fifo_tb_top.sv
`timescale 1ns/1ps
module tx_frame_fifo_tb_top;

  localparam int BUF = 256;
  localparam int THR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic wrReady;
  logic kick = 1'b0, errAck = 1'b0, emptyAck = 1'b0;
  logic [THR_W-1:0] thrCfg = '1;
  logic padEn = 1'b0, autoCrc = 1'b1;
  logic outValid, outReady = 1'b0, outLast, txErr, txEmpty;
  logic [7:0] outData;

  always #5 clk = ~clk;

  tx_frame_fifo #(.BUF_BYTES(BUF), .THR_W(THR_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .kick(kick), .errAck(errAck), .emptyAck(emptyAck), .thrCfg(thrCfg),
    .padEn(padEn), .autoCrc(autoCrc), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .txErr(txErr), .txEmpty(txEmpty)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] model [BUF];
  int mCnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int needOf(input int len, input bit crc);
    int n = len + (crc ? 16 : 20);
    return (n > BUF) ? BUF : n;
  endfunction

  function automatic int modelLen();
    return int'(model[0]) | (int'(model[1]) << 8);
  endfunction

  // Write one word from an idle state; returns whether a send started.
  task automatic doWrite(input logic [31:0] w, input string req, output bit sent);
    int t = int'(thrCfg);
    sent = 0;
    if (mCnt == 0 && int'(w[15:0]) > BUF - 16) begin
      sent = 0;
    end else begin
      if (mCnt + 4 <= BUF) begin
        for (int b = 0; b < 4; b++) model[mCnt + b] = w[8*b +: 8];
        mCnt += 4;
      end
      sent = (t != 63) && (mCnt >= 32*t + 4) && (mCnt >= needOf(modelLen(), autoCrc));
    end
    wrValid = 1'b1; wrData = w;
    @(negedge clk);
    wrValid = 1'b0;
    chk(outValid == sent, req, int'(outValid), int'(sent));
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk(outValid == 1'b1, "R9 kick start", int'(outValid), 1);
  endtask

  task automatic pulseErrAck();
    errAck = 1'b1;
    @(negedge clk);
    errAck = 1'b0;
    mCnt = 0;
  endtask

  // Drain one frame with random backpressure and compare to the model.
  task automatic collect(input string req);
    int len = modelLen();
    int dataLen = (len + 14 > BUF - 2) ? BUF - 2 : len + 14;
    int fl = (padEn && len + 14 < 60) ? 60 : dataLen;
    int idx = 0, bad = 0, firstAct = 0, firstExp = 0, lastBad = 0;
    bit holdPend = 0;
    logic [7:0] heldData = 0;
    bit done = 0;
    chk(wrReady == 1'b0, "R12 busy during send", int'(wrReady), 0);
    while (!done) begin
      outReady = ($urandom % 4) != 0;
      if (holdPend) begin
        chk(outValid && outData == heldData, "R13 held byte", int'(outData), int'(heldData));
        holdPend = 0;
      end
      if (outValid && outReady) begin
        int e = (idx < dataLen) ? int'(model[idx + 2]) : 0;
        if (int'(outData) != e && bad == 0) begin firstAct = outData; firstExp = e; end
        if (int'(outData) != e) bad++;
        if (outLast != (idx == fl - 1)) lastBad++;
        if (outLast) done = 1;
        idx++;
        if (idx > BUF) done = 1;
      end else if (outValid) begin
        holdPend = 1; heldData = outData;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(bad == 0, req, firstAct, firstExp);
    chk(idx == fl, "R8 frame length", idx, fl);
    chk(lastBad == 0, "R13 last flag", lastBad, 0);
    chk(!outValid && txEmpty, "R10 empty flag", int'(txEmpty), 1);
    mCnt = 0;
  endtask

  task automatic runFrame(input int len, input int thr, input bit pad, input bit crc,
                          input string req, output int words);
    bit sent;
    thrCfg = THR_W'(thr); padEn = pad; autoCrc = crc;
    doWrite({16'($urandom), 16'(len)}, "R7 auto start", sent);
    words = 1;
    while (!sent) begin
      if ((thr == 63 && mCnt >= needOf(len, crc)) || mCnt >= BUF) begin
        doKick();
        sent = 1;
      end else begin
        doWrite($urandom, "R7 auto start", sent);
        words++;
      end
    end
    collect(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int words;
    bit sent;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wrReady && !outValid && !txErr && !txEmpty, "R1 reset state",
        {wrReady, outValid, txErr, txEmpty}, 4'b1000);

    // R3 overflow: header len 240, 64 more words, last one dropped
    thrCfg = '1; padEn = 0; autoCrc = 1;
    doWrite(32'h1111_00F0, "R7 no start", sent);
    for (int i = 0; i < 64; i++) doWrite($urandom, "R7 no start", sent);
    chk(mCnt == BUF, "R3 model full", mCnt, BUF);
    doKick();
    collect("R3 overflow word discarded");

    // R4 oversized length refused
    doWrite(32'hABCD_00F1, "R4 no start", sent);
    chk(txErr == 1'b1, "R4 error flag", int'(txErr), 1);
    runFrame(10, 63, 0, 1, "R4 buffer left empty", words);
    chk(words == 7, "R4 words to complete", words, 7);

    // R11 acknowledge clears flag and empties
    pulseErrAck();
    chk(txErr == 1'b0, "R11 flag cleared", int'(txErr), 0);
    thrCfg = 0; autoCrc = 1;
    doWrite(32'h0000_0032, "R7 no start", sent);
    doWrite($urandom, "R7 no start", sent);
    pulseErrAck();
    runFrame(6, 0, 0, 1, "R11 new length word", words);
    chk(words == 6, "R11 words after ack", words, 6);

    // R5 completeness
    runFrame(20, 0, 0, 1, "R5 frame", words);
    chk(words == 9, "R5 autoCrc on", words, 9);
    runFrame(20, 0, 0, 0, "R5 frame", words);
    chk(words == 10, "R5 autoCrc off", words, 10);
    runFrame(240, 0, 0, 0, "R5 frame", words);
    chk(words == 64, "R5 capped need", words, 64);

    // R6 fill level
    runFrame(0, 1, 0, 1, "R6 frame", words);
    chk(words == 9, "R6 level 1", words, 9);
    runFrame(0, 2, 0, 1, "R6 frame", words);
    chk(words == 17, "R6 level 2", words, 17);
    runFrame(0, 63, 0, 1, "R6 frame", words);
    chk(words == 4, "R6 disabled", words, 4);

    // R8 padding
    runFrame(10, 0, 1, 1, "R8 padded frame", words);
    runFrame(10, 0, 0, 1, "R8 unpadded frame", words);

    // R9 kick on an incomplete frame
    thrCfg = '1; padEn = 0; autoCrc = 1;
    doWrite(32'h55AA_0064, "R7 no start", sent);
    doWrite($urandom, "R7 no start", sent);
    doKick();
    collect("R9 forced send contents");

    // R10 empty flag acknowledge
    emptyAck = 1'b1;
    @(negedge clk);
    emptyAck = 1'b0;
    chk(txEmpty == 1'b0, "R10 emptyAck clears", int'(txEmpty), 0);

    // R2 random frames
    for (int f = 0; f < 40; f++) begin
      int thrSel = $urandom % 5;
      runFrame($urandom % 121, (thrSel == 4) ? 63 : thrSel,
               1'($urandom), 1'($urandom), "R2 byte order and content", words);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule